// File: doc/BRIEF.md
# Page-Mode Nonvolatile Write Sequencer

This block is the device-side control of a byte-wide memory that is programmed one page at a time. The active-low chip select, output enable and write enable strobes are decoded against the system clock. Each qualified byte load latches an address and a data byte into a page buffer. Every load after the first must target the page that the first load opened. A load also rearms an inactivity window. When that window runs out, an internal programming phase starts, and at its end the whole buffered page is committed to the array at once.

Reads that arrive during programming do not return array data. They return a polling byte. Bit 7 is the inverse of bit 7 of the last accepted byte, and bit 6 flips after each completed read. A host can watch either bit to see when programming has finished. Write-inhibit rules, a minimum write-enable width and output-enable control of the data bus keep stray strobes from corrupting the array or driving the bus.

The array is a register model that resets to the erased value 0xFF. The window length, the programming time and the minimum strobe width are parameters given in clock cycles.

Top module: `pgw_sequencer`

## Requirements
- R1: `dout_en` is high exactly when `cs_n` and `oe_n` are both low. Otherwise the bus is released (`dout_en` low).
- R2: After reset no programming is in progress, and every array location reads 0xFF.
- R3: A byte load can happen only while `cs_n` and `we_n` are both low and `oe_n` is high. A strobe made with `oe_n` low or with `cs_n` held high changes nothing.
- R4: A write cycle whose active period lasts fewer than `MIN_WE` clock cycles is discarded.
- R5: The address is taken in the first cycle of the write cycle, which is when the later of `cs_n`/`we_n` falls. The data is the `din` value in the last active cycle, before the first of the two strobes rises.
- R6: Accepted loads into one page (page = `addr[ADDR_W-1:OFS_W]`, offset = `addr[OFS_W-1:0]`, up to 2**OFS_W bytes) are written to the array together. Page locations that were not loaded keep their old contents.
- R7: A load whose page differs from the page of the first load is ignored, and it does not extend the window.
- R8: Programming begins `WIN_CYC` cycles after the registered start of the last accepted load and lasts `PROG_CYC` cycles. The array shows the new data only when programming ends.
- R9: During programming, a read at any address returns bit 7 inverted and bits 5..0 unchanged, taken from the last accepted byte.
- R10: During programming, bit 6 starts at 0 and inverts once after each completed read (at the release of `cs_n` or `oe_n`).
- R11: Write cycles that occur during programming are ignored. A new page can start only after programming ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data, or the polling byte while programming |
| dout_en | output | 1 | Bus drive enable; low means high-impedance |

## Verification
Read data and `dout_en` are combinational from the strobes and the present state. Each read check therefore samples a quarter period after the strobes are driven at a falling clock edge. Programming starts on the `WIN_CYC`-th rising edge after the edge that registered the start of the last accepted load, and the array changes `PROG_CYC` edges after that. The bench records the cycle count at that start and places reads on both sides of each boundary. The toggle bit changes on the rising edge after a read is released, so every polling read is two cycles long and its expected bit 6 follows from the reads completed since programming began.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;

    // Strobe events decoded from the bus, one cycle each.
    typedef struct packed {
        logic rd_act;
        logic rd_end;
        logic wr_act;
        logic wr_start;
        logic commit;
    } bus_ev_t;

    // Status byte seen by the host while a page is being programmed.
    function automatic logic [BYTE_W-1:0] poll_byte(input logic [BYTE_W-1:0] last,
                                                    input logic tog);
        poll_byte = {~last[BYTE_W-1], tog, last[BYTE_W-3:0]};
    endfunction

endpackage

// File: rtl/pgw_bus_decode.sv
module pgw_bus_decode
    import pgw_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned MIN_WE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output bus_ev_t           ev,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [BYTE_W-1:0] lat_data
);

    localparam int unsigned PW_W = $clog2(MIN_WE + 1);

    logic            wr_now;
    logic            wr_q;
    logic            rd_now;
    logic            rd_q;
    logic [PW_W-1:0] pw;

    assign wr_now = !cs_n && !we_n && oe_n;
    assign rd_now = !cs_n && !oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            pw       <= '0;
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            wr_q <= wr_now;
            rd_q <= rd_now;
            if (wr_now && !wr_q) begin
                pw       <= PW_W'(1);
                lat_addr <= addr;
            end else if (wr_now && pw != PW_W'(MIN_WE)) begin
                pw <= pw + 1'b1;
            end
            if (wr_now) begin
                lat_data <= din;
            end
        end
    end

    assign ev.rd_act   = rd_now;
    assign ev.rd_end   = rd_q && !rd_now;
    assign ev.wr_act   = wr_now;
    assign ev.wr_start = wr_now && !wr_q;
    // End of a long-enough write cycle: first rise of cs_n or we_n.
    assign ev.commit   = wr_q && (cs_n || we_n) && (pw == PW_W'(MIN_WE));

    // R3: a committed load always follows a cycle with a legal write strobe.
    a_r3_commit_after_write: assert property (@(posedge clk) disable iff (rst)
        ev.commit |-> $past(!cs_n && !we_n && oe_n));

endmodule

// File: rtl/pgw_page_ctrl.sv
module pgw_page_ctrl
    import pgw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned OFS_W    = 7,
    parameter int unsigned WIN_CYC  = 16,
    parameter int unsigned PROG_CYC = 40
) (
    input  logic                    clk,
    input  logic                    rst,
    input  bus_ev_t                 ev,
    input  logic [ADDR_W-1:0]       lat_addr,
    input  logic [BYTE_W-1:0]       lat_data,
    output phase_e                  phase,
    output logic [ADDR_W-OFS_W-1:0] page_q,
    output logic [BYTE_W-1:0]       pbuf [1 << OFS_W],
    output logic [(1<<OFS_W)-1:0]   pvld,
    output logic [BYTE_W-1:0]       last_byte,
    output logic                    tog,
    output logic                    burn
);

    localparam int unsigned PAGE_N = 1 << OFS_W;
    localparam int unsigned PG_W   = ADDR_W - OFS_W;
    localparam int unsigned WC_W   = $clog2(WIN_CYC + 1);
    localparam int unsigned PC_W   = $clog2(PROG_CYC + 1);

    logic [PG_W-1:0]  lat_pg;
    logic [OFS_W-1:0] lat_ofs;
    logic             accept;
    logic             expire;
    logic [WC_W-1:0]  since_fall;
    logic [WC_W-1:0]  win_cnt;
    logic [WC_W-1:0]  fresh_win;
    logic [PC_W-1:0]  prog_cnt;

    assign lat_pg  = lat_addr[ADDR_W-1:OFS_W];
    assign lat_ofs = lat_addr[OFS_W-1:0];

    assign accept = ev.commit &&
                    ((phase == PH_IDLE) || ((phase == PH_LOAD) && (lat_pg == page_q)));
    assign expire = (phase == PH_LOAD) && (win_cnt == WC_W'(WIN_CYC)) &&
                    !ev.wr_act && !accept;
    assign burn   = (phase == PH_PROG) && (prog_cnt == PC_W'(PROG_CYC - 1));

    // Window age measured from the falling edge that opened the accepted load.
    assign fresh_win = (since_fall == WC_W'(WIN_CYC)) ? WC_W'(WIN_CYC) : since_fall + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_fall <= '0;
        end else if (ev.wr_start) begin
            since_fall <= WC_W'(1);
        end else if (since_fall != WC_W'(WIN_CYC)) begin
            since_fall <= since_fall + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            page_q    <= '0;
            win_cnt   <= '0;
            prog_cnt  <= '0;
            tog       <= 1'b0;
            last_byte <= '0;
        end else begin
            if (accept) begin
                last_byte <= lat_data;
                win_cnt   <= fresh_win;
            end else if (win_cnt != WC_W'(WIN_CYC)) begin
                win_cnt <= win_cnt + 1'b1;
            end
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase  <= PH_LOAD;
                        page_q <= lat_pg;
                    end
                end
                PH_LOAD: begin
                    if (expire) begin
                        phase    <= PH_PROG;
                        prog_cnt <= '0;
                        tog      <= 1'b0;
                    end
                end
                PH_PROG: begin
                    if (burn) begin
                        phase <= PH_IDLE;
                    end else begin
                        prog_cnt <= prog_cnt + 1'b1;
                    end
                    if (ev.rd_end) begin
                        tog <= ~tog;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || burn) begin
            pvld <= '0;
        end else if (accept) begin
            pvld[lat_ofs] <= 1'b1;
        end
    end

    for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
        logic hit;
        assign hit = accept && (lat_ofs == OFS_W'(g));
        always_ff @(posedge clk) begin
            if (hit) begin
                pbuf[g] <= lat_data;
            end
        end
    end

    // R6: a page being gathered always holds at least one byte.
    a_r6_load_nonempty: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD) |-> (pvld != '0));

    // R7: the locked page cannot move while bytes are being gathered.
    a_r7_page_locked: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD && $past(phase == PH_LOAD)) |-> $stable(page_q));

    // R11: the buffer is frozen during programming.
    a_r11_buffer_frozen: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PROG && $past(phase == PH_PROG)) |-> $stable(pvld));

    // R10: bit 6 only moves when a read has just completed.
    a_r10_tog_hold: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PROG && $past(phase == PH_PROG) && !$past(ev.rd_end)) |-> $stable(tog));

endmodule

// File: rtl/pgw_array.sv
module pgw_array
    import pgw_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned OFS_W  = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    burn,
    input  logic [ADDR_W-OFS_W-1:0] page,
    input  logic [BYTE_W-1:0]       pbuf [1 << OFS_W],
    input  logic [(1<<OFS_W)-1:0]   pvld,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [BYTE_W-1:0]       rdata
);

    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned PAGE_N = 1 << OFS_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (burn) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (pvld[i]) begin
                    mem[{page, OFS_W'(i)}] <= pbuf[i];
                end
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pgw_sequencer.sv
module pgw_sequencer
    import pgw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned OFS_W    = 7,
    parameter int unsigned MIN_WE   = 3,
    parameter int unsigned WIN_CYC  = 16,
    parameter int unsigned PROG_CYC = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);

    localparam int unsigned PAGE_N = 1 << OFS_W;
    localparam int unsigned PG_W   = ADDR_W - OFS_W;

    bus_ev_t           ev;
    logic [ADDR_W-1:0] lat_addr;
    logic [BYTE_W-1:0] lat_data;
    phase_e            phase;
    logic [PG_W-1:0]   page_q;
    logic [BYTE_W-1:0] pbuf [PAGE_N];
    logic [PAGE_N-1:0] pvld;
    logic [BYTE_W-1:0] last_byte;
    logic              tog;
    logic              burn;
    logic [BYTE_W-1:0] rdata;

    pgw_bus_decode #(.ADDR_W(ADDR_W), .MIN_WE(MIN_WE)) u_dec (
        .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .ev(ev), .lat_addr(lat_addr), .lat_data(lat_data)
    );

    pgw_page_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_CYC(WIN_CYC),
                    .PROG_CYC(PROG_CYC)) u_ctl (
        .clk(clk), .rst(rst), .ev(ev), .lat_addr(lat_addr), .lat_data(lat_data),
        .phase(phase), .page_q(page_q), .pbuf(pbuf), .pvld(pvld),
        .last_byte(last_byte), .tog(tog), .burn(burn)
    );

    pgw_array #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_arr (
        .clk(clk), .rst(rst), .burn(burn), .page(page_q), .pbuf(pbuf),
        .pvld(pvld), .raddr(addr), .rdata(rdata)
    );

    assign dout_en = ev.rd_act;
    assign dout    = (phase == PH_PROG) ? poll_byte(last_byte, tog) : rdata;

    // R1: bus released whenever either strobe is high.
    a_r1_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        (cs_n || oe_n) |-> !dout_en);

    // R9: polling bit 7 is the inverse of the last loaded byte.
    a_r9_poll_bit7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PROG && dout_en) |-> (dout[7] != last_byte[7]));

endmodule

// File: tb/pgw_sequencer_test.sv
module pgw_sequencer_test;

    localparam int WIN  = 16;
    localparam int PROG = 40;
    localparam int MINW = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       we_n = 1'b1;
    logic [8:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_en;

    int  cyc = 0;
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  mon_req = 1'b0;
    bit  done = 1'b0;
    int  st;
    int  st2;

    string      q_tag[$];
    logic       q_en[$];
    logic [7:0] q_val[$];

    pgw_sequencer #(.ADDR_W(9), .OFS_W(7), .MIN_WE(MINW), .WIN_CYC(WIN),
                    .PROG_CYC(PROG)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops one expected item per requested sample.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mon_req) begin : pop_one
                string      t;
                logic       e_en;
                logic [7:0] e_v;
                t    = q_tag.pop_front();
                e_en = q_en.pop_front();
                e_v  = q_val.pop_front();
                n_cmp++;
                if (dout_en !== e_en || (e_en && dout !== e_v)) begin
                    n_bad++;
                    $display("FAIL %s: en=%b data=%h expected en=%b data=%h",
                             t, dout_en, dout, e_en, e_v);
                end
                mon_req = 1'b0;
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_item(input string t, input logic en, input logic [7:0] v);
        q_tag.push_back(t);
        q_en.push_back(en);
        q_val.push_back(v);
        mon_req = 1'b1;
    endtask

    // Two-cycle read: strobes low for one cycle, then released for one.
    task automatic rd(input logic [8:0] a, input logic [7:0] v, input string t);
        addr = a;
        cs_n = 1'b0;
        oe_n = 1'b0;
        expect_item(t, 1'b1, v);
        step();
        cs_n = 1'b1;
        oe_n = 1'b1;
        step();
    endtask

    task automatic bus_off(input logic c, input logic o, input string t);
        cs_n = c;
        oe_n = o;
        expect_item(t, 1'b0, 8'h00);
        step();
        cs_n = 1'b1;
        oe_n = 1'b1;
        step();
    endtask

    task automatic wr_full(input logic [8:0] a0, input logic [7:0] d0,
                           input logic [8:0] a1, input logic [7:0] d1,
                           input int len, input bit oe_lo, input bit no_cs,
                           input bit we_lead, output int s);
        if (we_lead) begin
            addr = 9'h1FF;
            we_n = 1'b0;
            step();
        end
        addr = a0;
        din  = d0;
        we_n = 1'b0;
        cs_n = no_cs;
        oe_n = !oe_lo;
        s    = cyc;
        step();
        addr = a1;
        din  = d1;
        repeat (len - 1) step();
        cs_n = 1'b1;
        we_n = 1'b1;
        oe_n = 1'b1;
        din  = 8'hEE;
        step();
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d, output int s);
        wr_full(a, d, a, d, 4, 1'b0, 1'b0, 1'b0, s);
    endtask

    task automatic wait_to(input int c);
        while (cyc != c) step();
    endtask

    initial begin
        int dummy;
        repeat (4) step();
        rst = 1'b0;
        step();

        // Reset state and bus release.
        rd(9'h005, 8'hFF, "R2 erased after reset");
        bus_off(1'b0, 1'b1, "R1 oe high releases bus");
        bus_off(1'b1, 1'b0, "R1 cs high releases bus");

        // Page 1 gather: offsets 0x05, 0x06 and 0x7F.
        wr(9'h085, 8'hA5, dummy);
        wr(9'h086, 8'h3C, dummy);
        wr(9'h0FF, 8'h81, st);
        wr(9'h105, 8'h55, dummy);   // other page: ignored, no window restart (R7)

        wait_to(st + WIN);
        rd(9'h085, 8'hFF, "R8 not yet programming at window edge");
        rd(9'h085, 8'h41, "R9 R10 first poll after window");
        rd(9'h000, 8'h01, "R10 bit 6 inverted after read");
        wr(9'h090, 8'h77, dummy);   // during programming: ignored (R11)
        wait_to(st + WIN + PROG);
        rd(9'h085, 8'h41, "R8 still programming in last cycle");
        rd(9'h085, 8'hA5, "R6 R8 byte committed at end");
        rd(9'h086, 8'h3C, "R6 second byte committed");
        rd(9'h0FF, 8'h81, "R6 last offset committed");
        rd(9'h087, 8'hFF, "R6 unloaded offset untouched");
        rd(9'h105, 8'hFF, "R7 foreign page load dropped");
        rd(9'h090, 8'hFF, "R11 write while programming dropped");

        // Page 0: inhibited and short strobes, then a minimum-width load.
        wr_full(9'h010, 8'h11, 9'h010, 8'h11, 4, 1'b1, 1'b0, 1'b0, dummy);
        wr_full(9'h011, 8'h22, 9'h011, 8'h22, MINW - 1, 1'b0, 1'b0, 1'b0, dummy);
        wr_full(9'h013, 8'h44, 9'h013, 8'h44, 4, 1'b0, 1'b1, 1'b0, dummy);
        wr_full(9'h012, 8'h99, 9'h014, 8'h33, MINW, 1'b0, 1'b0, 1'b1, st2);
        wait_to(st2 + WIN + PROG + 2);
        rd(9'h010, 8'hFF, "R3 oe low blocks write");
        rd(9'h011, 8'hFF, "R4 short pulse discarded");
        rd(9'h013, 8'hFF, "R3 cs high blocks write");
        rd(9'h012, 8'h33, "R5 first address, last data");
        rd(9'h014, 8'hFF, "R5 later address not used");

        step();
        step();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule